// File: doc/BRIEF.md
# Ethernet Buffer Descriptor Manager

This block owns the table of transmit and receive buffer descriptors for a DMA-based Ethernet MAC. The host reads and writes the table and two control registers through a simple one-cycle register bus. Each descriptor is two 32-bit words. The even word is a header carrying the length, a go flag, an interrupt request and a wrap flag. The odd word is the buffer pointer. A single programmable split count divides the table: descriptors below the split are for transmit, and those at or above it are for receive.

Two walkers run over their own regions. The transmit walker waits for a descriptor whose go flag is set. It then reads the pointer and offers the length, the pointer and the first-word byte enables to a transmit data engine, and holds that offer until the engine reports completion. On completion it writes the header back once, with the go flag cleared and the error flags in the low bits. The receive walker works the same way. It offers a buffer to a receive engine and, when the engine finishes, writes back the received length and the error flags. Both walkers share one table access per cycle with the host. The host always wins that access, and the two walkers alternate between themselves.

Top module: `eth_bd_mgr`

## Requirements
- R1: After `rst_n` is released, the mode register reads 0x0000_0800, which is the halt bit 11 set. The split register reads NDESC/2. `tx_req`, `rx_req` and `irq` are low.
- R2: A host access with `hb_addr[AW]`=0 reaches table word `hb_addr[AW-1:0]`. A host access with `hb_addr[AW]`=1 reaches a register: `hb_addr[0]`=0 selects the mode register and `hb_addr[0]`=1 selects the split count, and a split count written above NDESC is stored as NDESC. Read data appears on `hb_rdata` in the cycle after the read.
- R3: A transmit header with bit 15 set is followed by its pointer word. The walker then raises `tx_req` with `tx_len` equal to header bits 31:16 and `tx_addr` equal to the pointer, and holds all three stable until `tx_done`.
- R4: A header whose bit 15 is clear stalls its walker on that same descriptor. Once the host sets bit 15, that descriptor is served; it is never skipped.
- R5: The byte enables follow pointer bits 1:0: offset 0 gives 4'b1111, 1 gives 4'b0111, 2 gives 4'b0011 and 3 gives 4'b0001.
- R6: A transmit header that is ready but has a length above MAX_LEN (1536) raises no `tx_req`. Its header is written back with bit 15 cleared and bit 3 set.
- R7: A transmit write-back keeps bits 31:16, 14 and 13, clears bit 15 and bits 12:4, and writes `tx_err[2:0]` into bits 2:0 with bit 3 at 0.
- R8: Receive descriptors start at word 2×split. `rx_req` carries the pointer and the R5 enables. On `rx_done` the header becomes {`rx_len`, 0, bit 14, bit 13, 9'b0, `rx_err`}.
- R9: After a write-back, a set wrap bit (13) sends the walker to the first descriptor of its region. Otherwise the walker goes to the next descriptor, and the last descriptor of a region also returns it to the first.
- R10: `irq` pulses high for exactly one cycle, in the cycle after a write-back whose header bit 14 was set.
- R11: When the host accesses the table, no walker touches the table in that cycle; a walker that wanted it waits.
- R12: Setting mode bit 11 drops `tx_req` and `rx_req` and returns both walkers to the first descriptor of their regions. Clearing it resumes the walk from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_sel | input | 1 | Host access strobe |
| hb_we | input | 1 | Host write (1) or read (0) |
| hb_addr | input | AW+1 | Top bit selects registers; the low bits give the table word index |
| hb_wdata | input | 32 | Host write data |
| hb_rdata | output | 32 | Host read data, valid the cycle after the read |
| tx_req | output | 1 | Transmit buffer offered |
| tx_addr | output | 32 | Transmit buffer pointer |
| tx_be | output | 4 | Byte enables for the first transmit word |
| tx_len | output | 16 | Transmit frame length |
| tx_done | input | 1 | Transmit engine finished |
| tx_err | input | 3 | Transmit error flags: underrun, retry limit, late collision |
| rx_req | output | 1 | Receive buffer offered |
| rx_addr | output | 32 | Receive buffer pointer |
| rx_be | output | 4 | Byte enables for the first receive word |
| rx_done | input | 1 | Receive engine finished |
| rx_len | input | 16 | Received frame length |
| rx_err | input | 4 | Receive error flags |
| irq | output | 1 | Write-back interrupt pulse |

## Verification
Two functions can fall in the same cycle.

- **Host access and a walker's table step.** The bench provokes this by writing a receive header and then holding host reads with no idle cycle in between, while the receive walker is polling. The stalled `rx_req` is judged during the hold and its rise is judged after the hold ends.
- **Both walkers wanting the table at once.** This happens with both regions live and polling. The bench's cycle model predicts the alternation and compares every output on every clock.

// File: rtl/eth_bd_mgr.sv
module eth_bd_mgr #(
  parameter int NDESC    = 32,
  parameter int MAX_LEN  = 1536,
  parameter int SRST_BIT = 11
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        hb_sel,
  input  logic                        hb_we,
  input  logic [$clog2(2*NDESC):0]    hb_addr,
  input  logic [31:0]                 hb_wdata,
  output logic [31:0]                 hb_rdata,
  output logic                        tx_req,
  output logic [31:0]                 tx_addr,
  output logic [3:0]                  tx_be,
  output logic [15:0]                 tx_len,
  input  logic                        tx_done,
  input  logic [2:0]                  tx_err,
  output logic                        rx_req,
  output logic [31:0]                 rx_addr,
  output logic [3:0]                  rx_be,
  input  logic                        rx_done,
  input  logic [15:0]                 rx_len,
  input  logic [3:0]                  rx_err,
  output logic                        irq
);
  localparam int NW = 2 * NDESC;
  localparam int AW = $clog2(NW);
  localparam int IW = $clog2(NDESC);
  localparam int CW = $clog2(NDESC + 1);
  localparam logic [1:0] W_STAT = 2'd0, W_PTR = 2'd1, W_BUSY = 2'd2, W_WB = 2'd3;

  logic [31:0]   tbl [NW];
  logic [31:0]   mode_q, rdata_q;
  logic [CW-1:0] txn_q;
  logic [1:0]    st   [2];
  logic [IW-1:0] idx  [2];
  logic [17:0]   hdr  [2];
  logic [31:0]   ptr  [2];
  logic [3:0]    flg  [2];
  logic [15:0]   rlen_q;
  logic          rr_q, irq_q;

  logic [CW-1:0] size [2], base [2];
  logic [AW-1:0] wa   [2];
  logic [31:0]   rd   [2], wb [2];
  logic [IW-1:0] nidx [2];
  logic [1:0]    want, gnt, done;

  wire srst     = mode_q[SRST_BIT];
  wire host_tbl = hb_sel && !hb_addr[AW];

  assign done = {rx_done, tx_done};

  always_comb begin
    size[0] = txn_q;
    size[1] = CW'(NDESC) - txn_q;
    base[0] = '0;
    base[1] = txn_q;
    for (int c = 0; c < 2; c++) begin
      want[c] = !srst && (size[c] != '0) && (st[c] != W_BUSY);
      wa[c]   = AW'({base[c] + CW'(idx[c]), 1'b0}) | AW'(st[c] == W_PTR);
      rd[c]   = tbl[wa[c]];
      wb[c]   = {(c == 1) ? rlen_q : hdr[c][17:2], 1'b0, hdr[c][1:0], 9'b0, flg[c]};
      nidx[c] = (hdr[c][0] || (CW'(idx[c]) + CW'(1) == size[c])) ? '0 : idx[c] + IW'(1);
    end
  end

  assign gnt[0] = !host_tbl && want[0] && (!want[1] || !rr_q);
  assign gnt[1] = !host_tbl && want[1] && (!want[0] ||  rr_q);

  always_ff @(posedge clk) begin
    if (host_tbl && hb_we) tbl[hb_addr[AW-1:0]] <= hb_wdata;
    for (int c = 0; c < 2; c++)
      if (gnt[c] && st[c] == W_WB) tbl[wa[c]] <= wb[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 32'(1) << SRST_BIT;
      txn_q   <= CW'(NDESC / 2);
      rdata_q <= '0;
    end else if (hb_sel) begin
      if (hb_addr[AW]) begin
        if (hb_we) begin
          if (hb_addr[0]) txn_q  <= (hb_wdata > 32'(NDESC)) ? CW'(NDESC) : hb_wdata[CW-1:0];
          else            mode_q <= hb_wdata;
        end else begin
          rdata_q <= hb_addr[0] ? 32'(txn_q) : mode_q;
        end
      end else if (!hb_we) begin
        rdata_q <= tbl[hb_addr[AW-1:0]];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        st[c]  <= W_STAT;
        idx[c] <= '0;
        hdr[c] <= '0;
        ptr[c] <= '0;
        flg[c] <= '0;
      end
      rlen_q <= '0;
      rr_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        if (srst) begin
          st[c]  <= W_STAT;
          idx[c] <= '0;
        end else begin
          case (st[c])
            W_STAT: if (gnt[c] && rd[c][15]) begin
              hdr[c] <= {rd[c][31:16], rd[c][14:13]};
              if (c == 0 && rd[c][31:16] > 16'(MAX_LEN)) begin
                flg[c] <= 4'b1000;
                st[c]  <= W_WB;
              end else begin
                st[c]  <= W_PTR;
              end
            end
            W_PTR: if (gnt[c]) begin
              ptr[c] <= rd[c];
              st[c]  <= W_BUSY;
            end
            W_BUSY: if (done[c]) begin
              flg[c] <= (c == 1) ? rx_err : {1'b0, tx_err};
              if (c == 1) rlen_q <= rx_len;
              st[c]  <= W_WB;
            end
            default: if (gnt[c]) begin
              idx[c] <= nidx[c];
              st[c]  <= W_STAT;
            end
          endcase
        end
      end
      if (gnt[0])      rr_q <= 1'b1;
      else if (gnt[1]) rr_q <= 1'b0;
      irq_q <= (gnt[0] && st[0] == W_WB && hdr[0][1]) ||
               (gnt[1] && st[1] == W_WB && hdr[1][1]);
    end
  end

  assign hb_rdata = rdata_q;
  assign tx_req   = (st[0] == W_BUSY);
  assign tx_addr  = ptr[0];
  assign tx_be    = 4'b1111 >> ptr[0][1:0];
  assign tx_len   = hdr[0][17:2];
  assign rx_req   = (st[1] == W_BUSY);
  assign rx_addr  = ptr[1];
  assign rx_be    = 4'b1111 >> ptr[1][1:0];
  assign irq      = irq_q;
endmodule

// File: rtl/eth_bd_mgr_chk.sv
module eth_bd_mgr_chk #(
  parameter int MAX_LEN = 1536
) (
  input logic        clk,
  input logic        rst_n,
  input logic        host_tbl,
  input logic        srst,
  input logic        tx_ptr_phase,
  input logic        tx_req,
  input logic        tx_done,
  input logic [31:0] tx_addr,
  input logic [3:0]  tx_be,
  input logic [15:0] tx_len,
  input logic        rx_req
);
  assert_be_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_be == 4'b1111 || tx_be == 4'b0111 || tx_be == 4'b0011 || tx_be == 4'b0001));

  assert_len_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |-> (tx_len <= 16'(MAX_LEN)));

  assert_offer_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !tx_done && !srst) |=> (tx_req && $stable(tx_addr) && $stable(tx_len)));

  assert_halt_drops_R12: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (!tx_req && !rx_req));

  assert_host_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_tbl && tx_ptr_phase && !srst) |=> tx_ptr_phase);
endmodule

bind eth_bd_mgr eth_bd_mgr_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_tbl(host_tbl), .srst(srst),
  .tx_ptr_phase(st[0] == 2'd1), .tx_req(tx_req), .tx_done(tx_done),
  .tx_addr(tx_addr), .tx_be(tx_be), .tx_len(tx_len), .rx_req(rx_req)
);

// File: tb/test_eth_bd_mgr.sv
module test_eth_bd_mgr;
  localparam int ND = 8;
  localparam logic [4:0] A_MODE = 5'h10, A_SPLIT = 5'h11;

  logic clk = 0, rst_n = 0;
  logic hb_sel = 0, hb_we = 0;
  logic [4:0] hb_addr = 0;
  logic [31:0] hb_wdata = 0, hb_rdata;
  logic tx_req, rx_req, irq;
  logic [31:0] tx_addr, rx_addr;
  logic [3:0] tx_be, rx_be;
  logic [15:0] tx_len;
  logic tx_done = 0, rx_done = 0;
  logic [2:0] tx_err = 0;
  logic [15:0] rx_len = 0;
  logic [3:0] rx_err = 0;

  int checks = 0, failures = 0, irq_cnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  eth_bd_mgr #(.NDESC(ND)) i_eth_bd_mgr (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_we(hb_we), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .tx_req(tx_req), .tx_addr(tx_addr),
    .tx_be(tx_be), .tx_len(tx_len), .tx_done(tx_done), .tx_err(tx_err),
    .rx_req(rx_req), .rx_addr(rx_addr), .rx_be(rx_be), .rx_done(rx_done),
    .rx_len(rx_len), .rx_err(rx_err), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] be_exp(input logic [1:0] off);
    case (off)
      2'd0: be_exp = 4'b1111;
      2'd1: be_exp = 4'b0111;
      2'd2: be_exp = 4'b0011;
      default: be_exp = 4'b0001;
    endcase
  endfunction

  // behavioural reference model, stepped on each rising edge
  int m_st[2], m_idx[2], m_txn, sz[2], bs[2], wa[2];
  logic [31:0] m_tbl[2*ND];
  logic [31:0] m_hdr[2], m_ptr[2], m_mode, m_rd;
  logic [3:0] m_flg[2];
  logic [15:0] m_rlen;
  logic m_rr, m_irq, m_rdv, host, nirq;
  logic w[2], g[2], dn[2];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        m_st[c] = 0; m_idx[c] = 0; m_hdr[c] = 0; m_ptr[c] = 0; m_flg[c] = 0;
      end
      for (int i = 0; i < 2*ND; i++) m_tbl[i] = 0;
      m_txn = ND/2; m_mode = 32'h800; m_rlen = 0; m_rr = 0; m_irq = 0; m_rdv = 0; m_rd = 0;
    end else begin
      host = hb_sel && !hb_addr[4];
      sz[0] = m_txn; sz[1] = ND - m_txn; bs[0] = 0; bs[1] = m_txn;
      dn[0] = tx_done; dn[1] = rx_done;
      for (int c = 0; c < 2; c++) begin
        w[c]  = !m_mode[11] && sz[c] != 0 && m_st[c] != 2;
        wa[c] = 2*(bs[c] + m_idx[c]) + ((m_st[c] == 1) ? 1 : 0);
      end
      g[0] = !host && w[0] && (!w[1] || !m_rr);
      g[1] = !host && w[1] && (!w[0] || m_rr);
      nirq = 0;
      m_rdv = 0;
      if (hb_sel && !hb_we) begin
        m_rdv = 1;
        if (hb_addr[4]) m_rd = hb_addr[0] ? 32'(m_txn) : m_mode;
        else            m_rd = m_tbl[hb_addr[3:0]];
      end
      for (int c = 0; c < 2; c++) begin
        if (m_mode[11]) begin
          m_st[c] = 0; m_idx[c] = 0;
        end else if (m_st[c] == 0) begin
          if (g[c] && m_tbl[wa[c]][15]) begin
            m_hdr[c] = m_tbl[wa[c]];
            if (c == 0 && m_tbl[wa[c]][31:16] > 1536) begin m_flg[c] = 4'b1000; m_st[c] = 3; end
            else m_st[c] = 1;
          end
        end else if (m_st[c] == 1) begin
          if (g[c]) begin m_ptr[c] = m_tbl[wa[c]]; m_st[c] = 2; end
        end else if (m_st[c] == 2) begin
          if (dn[c]) begin
            m_flg[c] = (c == 1) ? rx_err : {1'b0, tx_err};
            if (c == 1) m_rlen = rx_len;
            m_st[c] = 3;
          end
        end else if (g[c]) begin
          m_tbl[wa[c]] = {(c == 1) ? m_rlen : m_hdr[c][31:16], 1'b0, m_hdr[c][14:13], 9'b0, m_flg[c]};
          nirq = nirq | m_hdr[c][14];
          m_idx[c] = (m_hdr[c][13] || m_idx[c] + 1 == sz[c]) ? 0 : m_idx[c] + 1;
          m_st[c] = 0;
        end
      end
      if (g[0]) m_rr = 1; else if (g[1]) m_rr = 0;
      m_irq = nirq;
      if (hb_sel && hb_we) begin
        if (!hb_addr[4]) m_tbl[hb_addr[3:0]] = hb_wdata;
        else if (hb_addr[0]) m_txn = (hb_wdata > ND) ? ND : int'(hb_wdata);
        else m_mode = hb_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(tx_req == (m_st[0] == 2), "R3 tx_req", 32'(tx_req), 32'(m_st[0] == 2));
      if (tx_req) begin
        chk(tx_addr == m_ptr[0], "R3 tx_addr", tx_addr, m_ptr[0]);
        chk(tx_len == m_hdr[0][31:16], "R3 tx_len", 32'(tx_len), 32'(m_hdr[0][31:16]));
        chk(tx_be == be_exp(m_ptr[0][1:0]), "R5 tx_be", 32'(tx_be), 32'(be_exp(m_ptr[0][1:0])));
      end
      chk(rx_req == (m_st[1] == 2), "R8 rx_req", 32'(rx_req), 32'(m_st[1] == 2));
      if (rx_req) begin
        chk(rx_addr == m_ptr[1], "R8 rx_addr", rx_addr, m_ptr[1]);
        chk(rx_be == be_exp(m_ptr[1][1:0]), "R5 rx_be", 32'(rx_be), 32'(be_exp(m_ptr[1][1:0])));
      end
      chk(irq == m_irq, "R10 irq", 32'(irq), 32'(m_irq));
      if (m_rdv) chk(hb_rdata == m_rd, "R2 rdata", hb_rdata, m_rd);
      if (irq) irq_cnt++;
    end
  end

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    hb_sel = 1; hb_we = 1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_sel = 0; hb_we = 0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [31:0] d);
    hb_sel = 1; hb_we = 0; hb_addr = a;
    @(negedge clk);
    hb_sel = 0;
    d = hb_rdata;
  endtask

  task automatic wait_tx();
    for (int i = 0; i < 40; i++) begin
      if (tx_req) break;
      @(negedge clk);
    end
  endtask

  task automatic wait_rx();
    for (int i = 0; i < 40; i++) begin
      if (rx_req) break;
      @(negedge clk);
    end
  endtask

  task automatic pulse_tx(input logic [2:0] e);
    tx_done = 1; tx_err = e; @(negedge clk); tx_done = 0; tx_err = 0;
  endtask

  task automatic pulse_rx(input logic [15:0] l, input logic [3:0] e);
    rx_done = 1; rx_len = l; rx_err = e; @(negedge clk); rx_done = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    bit saw;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_req && !rx_req && !irq, "R1 outputs idle", {tx_req, rx_req, irq}, 0);
    hr(A_MODE, d);  chk(d == 32'h800, "R1 mode", d, 32'h800);
    hr(A_SPLIT, d); chk(d == 4, "R1 split", d, 4);

    for (int i = 0; i < 2*ND; i++) hw(5'(i), 32'h0);
    hw(5'd3, 32'hA5A5_1234);
    hr(5'd3, d); chk(d == 32'hA5A5_1234, "R2 table rw", d, 32'hA5A5_1234);
    hw(A_SPLIT, 9);
    hr(A_SPLIT, d); chk(d == 8, "R2 split clamp", d, 8);
    hw(A_SPLIT, 2);

    hw(5'd1, 32'h1000_0002); hw(5'd0, 32'h0040_C000);
    hw(5'd3, 32'h2000_0000); hw(5'd2, 32'h07D0_A000);
    hw(5'd5, 32'h3000_0001); hw(5'd4, 32'h0000_C000);
    hw(A_MODE, 32'h0);

    wait_tx();
    chk(tx_req && tx_len == 64, "R3 tx offer len", 32'(tx_len), 64);
    chk(tx_addr == 32'h1000_0002, "R3 tx offer addr", tx_addr, 32'h1000_0002);
    chk(tx_be == 4'b0011, "R5 offset 2 enables", 32'(tx_be), 32'h3);
    wait_rx();
    chk(rx_req && rx_addr == 32'h3000_0001, "R8 rx offer addr", rx_addr, 32'h3000_0001);
    chk(rx_be == 4'b0111, "R5 offset 1 enables", 32'(rx_be), 32'h7);
    repeat (5) @(negedge clk);
    chk(tx_req && tx_addr == 32'h1000_0002, "R3 offer held", 32'(tx_req), 1);

    pulse_tx(3'b101);
    saw = 0;
    for (int i = 0; i < 12; i++) begin
      if (tx_req) saw = 1;
      @(negedge clk);
    end
    chk(!saw, "R6 no offer for long frame", 32'(saw), 0);
    hr(5'd0, d); chk(d == 32'h0040_4005, "R7 tx write-back", d, 32'h0040_4005);
    hr(5'd2, d); chk(d == 32'h07D0_2008, "R6 invalid length write-back", d, 32'h07D0_2008);
    chk(irq_cnt == 1, "R10 one pulse for irq-flagged descriptor", irq_cnt, 1);

    hw(5'd1, 32'h1000_0003); hw(5'd0, 32'h0064_8000);
    wait_tx();
    chk(tx_req && tx_len == 100, "R4 stalled descriptor served", 32'(tx_len), 100);
    chk(tx_addr == 32'h1000_0003 && tx_be == 4'b0001, "R5 offset 3 enables", 32'(tx_be), 32'h1);
    pulse_tx(3'b000);

    pulse_rx(16'h0055, 4'b0010);
    repeat (4) @(negedge clk);
    hr(5'd4, d); chk(d == 32'h0055_4002, "R8 rx write-back", d, 32'h0055_4002);
    chk(irq_cnt == 2, "R10 rx pulse", irq_cnt, 2);

    hw(5'd7, 32'h3100_0000); hw(5'd6, 32'h0000_8000);
    hb_sel = 1; hb_we = 0; hb_addr = 5'd0;
    repeat (6) @(negedge clk);
    hb_sel = 0;
    chk(!rx_req, "R11 walker waits for host", 32'(rx_req), 0);
    wait_rx();
    chk(rx_req && rx_addr == 32'h3100_0000, "R11 walker resumes", rx_addr, 32'h3100_0000);
    pulse_rx(16'h0010, 4'b0000);

    hw(5'd9, 32'h4000_0000); hw(5'd8, 32'h0000_A000);
    wait_rx();
    chk(rx_req && rx_addr == 32'h4000_0000, "R9 advance to next", rx_addr, 32'h4000_0000);
    pulse_rx(16'h0020, 4'b0001);
    hw(5'd5, 32'h5000_0000); hw(5'd4, 32'h0000_8000);
    wait_rx();
    chk(rx_req && rx_addr == 32'h5000_0000, "R9 wrap to region start", rx_addr, 32'h5000_0000);

    hw(5'd1, 32'h6000_0000); hw(5'd0, 32'h0008_8000);
    hw(A_MODE, 32'h800);
    @(negedge clk);
    chk(!tx_req && !rx_req, "R12 halt drops offers", {tx_req, rx_req}, 0);
    hw(A_MODE, 32'h0);
    wait_tx();
    chk(tx_req && tx_addr == 32'h6000_0000, "R12 tx restarts at first", tx_addr, 32'h6000_0000);
    wait_rx();
    chk(rx_req && rx_addr == 32'h5000_0000, "R12 rx restarts at first", rx_addr, 32'h5000_0000);

    repeat (4) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule